// File: doc/BRIEF.md
# PWM Period and Pulse-Width Capture

This block measures one digital input and reports two numbers: its period and the length of its active phase. Two input pins are synchronized, and a select bit chooses one of them. A polarity bit sets which edge is active. A prescaler divides the system clock into ticks, and a tick counter runs between edges. Every active edge zeroes the counter. Two capture registers watch the same selected input, one on each edge, so one register holds the period in ticks and the other holds the pulse width. No subtraction is needed afterwards.

The roles of the two registers follow the select bit. For convenience, the block also presents the values already routed as `period` and `width`. Each kind of capture has a sticky valid flag and a sticky overcapture flag. A timeout flag marks a period that was too long for the counter. All flags feed one interrupt through separate enables and are cleared by per-flag strobes. A change of configuration while the block is enabled restarts the measurement from a clean state.

Top module: `pwm_cap`

## Requirements
- R1: With prescaler value N on `cfg_psc`, one tick lasts N+1 clocks. The counter and prescaler phase restart on each active edge. A captured value equals floor(D/(N+1)) modulo 65536, where D is the number of clocks between the active edge and the captured edge.
- R2: The tick counter is 16 bits wide, counts up and wraps to zero. Each wrap while enabled sets the sticky `timeout` flag.
- R3: An active edge stores the period in the period register and zeroes the counter. An opposite edge stores the pulse width in the width register without disturbing the count.
- R4: `cfg_act_low`=0 makes the rising edge active and the high phase the pulse. `cfg_act_low`=1 makes the falling edge active and the low phase the pulse.
- R5: `cfg_sel`=0 measures `pin_a`, with `cap1` as the period and `cap2` as the width. `cfg_sel`=1 measures `pin_b`, with `cap2` as the period and `cap1` as the width. The pin that is not selected has no effect.
- R6: After a restart, the first active edge only zeroes the counter and arms the capture. Period and width captures happen only once armed.
- R7: Each period capture sets `per_vld` and each width capture sets `wid_vld`. A capture that arrives while its valid flag is already set also sets `per_ovr` or `wid_ovr`.
- R8: A one-cycle strobe on a `flag_clr` bit clears the matching flag on the next edge. The bit order is bit0 `per_vld`, bit1 `wid_vld`, bit2 `per_ovr`, bit3 `wid_ovr`, bit4 `timeout`. Clearing flags leaves the capture registers unchanged.
- R9: `irq` is the OR of three enabled sources. Enable bit0 gates `per_vld`, bit1 gates `per_ovr` or `wid_ovr`, and bit2 gates `timeout`.
- R10: A restart happens when `cfg_en` rises, or when `cfg_sel`, `cfg_act_low` or `cfg_psc` changes while enabled. On the next edge both capture registers, the count and all flags are zero.
- R11: While `cfg_en` is low, the counter stays at zero and no capture or flag is set by pin activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_a | input | 1 | Measured input, choice 0 |
| pin_b | input | 1 | Measured input, choice 1 |
| cfg_en | input | 1 | Run enable |
| cfg_sel | input | 1 | Pin select, 0 = pin_a, 1 = pin_b |
| cfg_act_low | input | 1 | Polarity, 1 = falling edge active |
| cfg_psc | input | 16 | Prescaler value N, tick = N+1 clocks |
| irq_en | input | 3 | Interrupt source enables |
| flag_clr | input | 5 | Per-flag clear strobes |
| cap1 | output | 16 | Capture register 1 |
| cap2 | output | 16 | Capture register 2 |
| period | output | 16 | Period in ticks, routed from the register holding it |
| width | output | 16 | Pulse width in ticks |
| per_vld | output | 1 | Period capture valid |
| wid_vld | output | 1 | Width capture valid |
| per_ovr | output | 1 | Period overcapture |
| wid_ovr | output | 1 | Width overcapture |
| timeout | output | 1 | Counter wrapped |
| irq | output | 1 | Interrupt |

## Verification
The assertions rely on a few assumptions about the inputs. Each level on the measured pin is assumed to last at least one clock. Any change of select, polarity or prescaler is assumed to be seen by the block as a restart in the same cycle, so the prescaler phase never exceeds the current setting and the edge detector never compares levels taken under two polarities. The bench respects these limits. It changes the pins only at falling clock edges and holds each level for at least two clocks. It changes the configuration either with the block disabled and then re-enabled, or as one deliberate change while running, so that a restart is produced on purpose.

// File: rtl/pwm_cap_pkg.sv
package pwm_cap_pkg;

  localparam int FLG_N = 5;
  localparam int IRQ_N = 3;

  // Sticky status flags; bit order matches the flag_clr strobe vector.
  typedef struct packed {
    logic timeout;   // bit 4
    logic wid_ovr;   // bit 3
    logic per_ovr;   // bit 2
    logic wid_vld;   // bit 1
    logic per_vld;   // bit 0
  } flags_t;

  // Interrupt source positions in irq_en.
  typedef enum int {
    IRQ_SRC_PER = 0,
    IRQ_SRC_OVR = 1,
    IRQ_SRC_TMO = 2
  } irq_src_e;

endpackage

// File: rtl/pwm_cap_sync.sv
module pwm_cap_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= stg_d[i];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pwm_cap_edge.sv
module pwm_cap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_a_i,
  input  logic sync_b_i,
  input  logic sel_i,
  input  logic act_low_i,
  input  logic run_i,
  input  logic restart_i,
  output logic act_edge_o,
  output logic opp_edge_o
);

  logic lvl;
  logic prev_q;
  logic prev_d;
  logic gate;

  // Normalised level: 1 means the input is in its active phase.
  assign lvl    = (sel_i ? sync_b_i : sync_a_i) ^ act_low_i;
  assign prev_d = lvl;
  assign gate   = run_i & ~restart_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign act_edge_o = gate &  lvl & ~prev_q;
  assign opp_edge_o = gate & ~lvl &  prev_q;

  // R3: two active edges need an opposite phase between them
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    act_edge_o |=> !act_edge_o);

  // R11: a disabled block reports no edges
  a_r11_no_edge_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !(act_edge_o || opp_edge_o));

endmodule

// File: rtl/pwm_cap_timebase.sv
module pwm_cap_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             zero_i,
  input  logic             edge_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);

  logic [PSC_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;

  assign tick = run_i & (pre_q == psc_i);

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (zero_i || !run_i || edge_i) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (tick) begin
      pre_d = '0;
      cnt_d = cnt_q + CNT_ONE;
    end else begin
      pre_d = pre_q + PSC_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  // Value the count reaches on this edge, including a tick landing now.
  assign cnt_o  = tick ? (cnt_q + CNT_ONE) : cnt_q;
  assign wrap_o = tick & (cnt_q == CNT_MAX) & ~zero_i;

  // R1: prescaler phase never passes the programmed divider
  a_r1_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !zero_i) |-> (pre_q <= psc_i));

  // R3: active edge leaves the counter at zero
  a_r3_edge_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> (cnt_q == '0));

  // R11: disabled counter holds zero
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_cap_capture.sv
module pwm_cap_capture
  import pwm_cap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             act_edge_i,
  input  logic             opp_edge_i,
  input  logic             sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  input  logic [FLG_N-1:0] clr_i,
  input  logic [IRQ_N-1:0] irq_en_i,
  output logic [CNT_W-1:0] cap1_o,
  output logic [CNT_W-1:0] cap2_o,
  output flags_t           flags_o,
  output logic             irq_o
);

  localparam int SLOTS = 2;

  logic             armed_q, armed_d;
  logic             per_cap, wid_cap;
  logic [CNT_W-1:0] cap_q [SLOTS];
  logic [CNT_W-1:0] cap_d [SLOTS];
  flags_t           flg_q, flg_d, clr;
  logic [IRQ_N-1:0] src;

  assign clr     = flags_t'(clr_i);
  assign per_cap = act_edge_i & armed_q;
  assign wid_cap = opp_edge_i & armed_q;

  always_comb begin
    armed_d = armed_q;
    if (restart_i || !run_i) armed_d = 1'b0;
    else if (act_edge_i)     armed_d = 1'b1;
  end

  // Slot i takes the period when it matches the select, the width otherwise.
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic wr;
    assign wr = (per_cap & (sel_i == 1'(i))) | (wid_cap & (sel_i != 1'(i)));
    always_comb begin
      cap_d[i] = cap_q[i];
      if (restart_i) cap_d[i] = '0;
      else if (wr)   cap_d[i] = cnt_i;
    end
  end

  always_comb begin
    flg_d = flg_q & ~clr;
    if (per_cap) begin
      flg_d.per_vld = 1'b1;
      if (flg_q.per_vld) flg_d.per_ovr = 1'b1;
    end
    if (wid_cap) begin
      flg_d.wid_vld = 1'b1;
      if (flg_q.wid_vld) flg_d.wid_ovr = 1'b1;
    end
    if (wrap_i && run_i) flg_d.timeout = 1'b1;
    if (restart_i) flg_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      flg_q   <= '0;
      for (int i = 0; i < SLOTS; i++) cap_q[i] <= '0;
    end else begin
      armed_q <= armed_d;
      flg_q   <= flg_d;
      for (int i = 0; i < SLOTS; i++) cap_q[i] <= cap_d[i];
    end
  end

  always_comb begin
    src = '0;
    src[IRQ_SRC_PER] = flg_q.per_vld;
    src[IRQ_SRC_OVR] = flg_q.per_ovr | flg_q.wid_ovr;
    src[IRQ_SRC_TMO] = flg_q.timeout;
  end

  assign irq_o   = |(src & irq_en_i);
  assign cap1_o  = cap_q[0];
  assign cap2_o  = cap_q[1];
  assign flags_o = flg_q;

  // R10: restart leaves captures and flags cleared
  a_r10_restart_clean: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cap_q[0] == '0 && cap_q[1] == '0 && flg_q == '0));

  // R6: unarmed active edge leaves both registers untouched
  a_r6_prime_only: assert property (@(posedge clk) disable iff (!rst_n)
    (act_edge_i && !armed_q && !restart_i) |=> ($stable(cap_q[0]) && $stable(cap_q[1])));

  // R7: repeated period capture flags an overcapture
  a_r7_per_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (per_cap && flg_q.per_vld) |=> flg_q.per_ovr);

  // R2: timeout only rises after a counter wrap
  a_r2_timeout_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q.timeout) |-> $past(wrap_i));

endmodule

// File: rtl/pwm_cap.sv
module pwm_cap
  import pwm_cap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             cfg_en,
  input  logic             cfg_sel,
  input  logic             cfg_act_low,
  input  logic [PSC_W-1:0] cfg_psc,
  input  logic [IRQ_N-1:0] irq_en,
  input  logic [FLG_N-1:0] flag_clr,
  output logic [CNT_W-1:0] cap1,
  output logic [CNT_W-1:0] cap2,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] width,
  output logic             per_vld,
  output logic             wid_vld,
  output logic             per_ovr,
  output logic             wid_ovr,
  output logic             timeout,
  output logic             irq
);

  localparam int RST_N = 2;

  logic [RST_N-1:0] rst_q;
  logic             rst_sn;
  logic [1:0]       pins_s;
  logic             en_q, sel_q, low_q;
  logic [PSC_W-1:0] psc_q;
  logic             restart;
  logic             act_edge, opp_edge;
  logic [CNT_W-1:0] cnt_val;
  logic             wrap;
  flags_t           flg;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[RST_N-2:0], 1'b1};
  end
  assign rst_sn = rst_q[RST_N-1];

  // Shadow of the configuration used to spot a change while running.
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
      low_q <= 1'b0;
      psc_q <= '0;
    end else begin
      en_q  <= cfg_en;
      sel_q <= cfg_sel;
      low_q <= cfg_act_low;
      psc_q <= cfg_psc;
    end
  end

  assign restart = cfg_en & (~en_q | (cfg_sel != sel_q) |
                             (cfg_act_low != low_q) | (cfg_psc != psc_q));

  pwm_cap_sync #(.STAGES(SYNC_N), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d_i   ({pin_b, pin_a}),
    .q_o   (pins_s)
  );

  pwm_cap_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_sn),
    .sync_a_i   (pins_s[0]),
    .sync_b_i   (pins_s[1]),
    .sel_i      (cfg_sel),
    .act_low_i  (cfg_act_low),
    .run_i      (cfg_en),
    .restart_i  (restart),
    .act_edge_o (act_edge),
    .opp_edge_o (opp_edge)
  );

  pwm_cap_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk    (clk),
    .rst_n  (rst_sn),
    .run_i  (cfg_en),
    .zero_i (restart),
    .edge_i (act_edge),
    .psc_i  (cfg_psc),
    .cnt_o  (cnt_val),
    .wrap_o (wrap)
  );

  pwm_cap_capture #(.CNT_W(CNT_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_sn),
    .run_i      (cfg_en),
    .restart_i  (restart),
    .act_edge_i (act_edge),
    .opp_edge_i (opp_edge),
    .sel_i      (cfg_sel),
    .cnt_i      (cnt_val),
    .wrap_i     (wrap),
    .clr_i      (flag_clr),
    .irq_en_i   (irq_en),
    .cap1_o     (cap1),
    .cap2_o     (cap2),
    .flags_o    (flg),
    .irq_o      (irq)
  );

  assign period  = cfg_sel ? cap2 : cap1;
  assign width   = cfg_sel ? cap1 : cap2;
  assign per_vld = flg.per_vld;
  assign wid_vld = flg.wid_vld;
  assign per_ovr = flg.per_ovr;
  assign wid_ovr = flg.wid_ovr;
  assign timeout = flg.timeout;

  // R5: routed period always comes from the register the select names
  a_r5_route: assert property (@(posedge clk) disable iff (!rst_sn)
    (cfg_sel == 1'b0) |-> (period == cap1 && width == cap2));

endmodule

// File: tb/pwm_cap_tb.sv
module pwm_cap_tb;

  typedef struct packed {
    logic        sel;
    logic        low;
    logic [15:0] psc;
    logic [15:0] act;
    logic [15:0] idl;
    logic [15:0] eper;
    logic [15:0] ewid;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{sel:1'b0, low:1'b0, psc:16'd0, act:16'd5,  idl:16'd7,  eper:16'd12, ewid:16'd5},
    '{sel:1'b1, low:1'b0, psc:16'd0, act:16'd3,  idl:16'd10, eper:16'd13, ewid:16'd3},
    '{sel:1'b0, low:1'b1, psc:16'd0, act:16'd4,  idl:16'd4,  eper:16'd8,  ewid:16'd4},
    '{sel:1'b1, low:1'b1, psc:16'd2, act:16'd9,  idl:16'd12, eper:16'd7,  ewid:16'd3},
    '{sel:1'b0, low:1'b0, psc:16'd3, act:16'd10, idl:16'd10, eper:16'd5,  ewid:16'd2},
    '{sel:1'b1, low:1'b0, psc:16'd1, act:16'd2,  idl:16'd5,  eper:16'd3,  ewid:16'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pin_a, pin_b;
  logic        cfg_en, cfg_sel, cfg_act_low;
  logic [15:0] cfg_psc;
  logic [2:0]  irq_en;
  logic [4:0]  flag_clr;
  logic [15:0] cap1, cap2, period, width;
  logic        per_vld, wid_vld, per_ovr, wid_ovr, timeout, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pwm_cap u_dut (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
    .cfg_en(cfg_en), .cfg_sel(cfg_sel), .cfg_act_low(cfg_act_low),
    .cfg_psc(cfg_psc), .irq_en(irq_en), .flag_clr(flag_clr),
    .cap1(cap1), .cap2(cap2), .period(period), .width(width),
    .per_vld(per_vld), .wid_vld(wid_vld), .per_ovr(per_ovr),
    .wid_ovr(wid_ovr), .timeout(timeout), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input logic sel, input logic low, input logic active);
    if (sel) pin_b = active ^ low;
    else     pin_a = active ^ low;
  endtask

  task automatic restart_cfg(input logic sel, input logic low, input logic [15:0] psc);
    cfg_en = 1'b0;
    pin_a  = low;
    pin_b  = low;
    cyc(1);
    cfg_sel     = sel;
    cfg_act_low = low;
    cfg_psc     = psc;
    cfg_en      = 1'b1;
    cyc(4);
  endtask

  task automatic pulses(input logic sel, input logic low, input int a, input int i, input int n);
    set_pin(sel, low, 1'b0);
    cyc(6);
    for (int k = 0; k < n; k++) begin
      set_pin(sel, low, 1'b1);
      cyc(a);
      set_pin(sel, low, 1'b0);
      cyc(i);
    end
    cyc(5);
  endtask

  task automatic clear_all();
    flag_clr = 5'b11111;
    cyc(1);
    flag_clr = 5'b00000;
    cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_a = 1'b0; pin_b = 1'b0;
    cfg_en = 1'b0; cfg_sel = 1'b0; cfg_act_low = 1'b0; cfg_psc = '0;
    irq_en = '0; flag_clr = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // Reset state
    chk("R10", "reset cap1", cap1, 0);
    chk("R10", "reset cap2", cap2, 0);
    chk("R7", "reset per_vld", per_vld, 0);
    chk("R2", "reset timeout", timeout, 0);
    chk("R9", "reset irq", irq, 0);

    // Table: R1 R3 R4 R5 over select, polarity and prescaler
    for (int v = 0; v < NV; v++) begin
      restart_cfg(VECS[v].sel, VECS[v].low, VECS[v].psc);
      pulses(VECS[v].sel, VECS[v].low, VECS[v].act, VECS[v].idl, 3);
      chk("R1", $sformatf("vec%0d period", v), period, VECS[v].eper);
      chk("R4", $sformatf("vec%0d width", v), width, VECS[v].ewid);
      chk("R5", $sformatf("vec%0d period register", v),
          VECS[v].sel ? cap2 : cap1, VECS[v].eper);
      chk("R3", $sformatf("vec%0d width register", v),
          VECS[v].sel ? cap1 : cap2, VECS[v].ewid);
      chk("R7", $sformatf("vec%0d per_ovr after two periods", v), per_ovr, 1);
    end

    // R6 and R7: two active edges give exactly one period capture
    restart_cfg(1'b0, 1'b0, 16'd0);
    pulses(1'b0, 1'b0, 4, 6, 2);
    chk("R6", "single period value", period, 10);
    chk("R7", "per_vld single", per_vld, 1);
    chk("R7", "per_ovr single", per_ovr, 0);
    chk("R7", "wid_ovr after two widths", wid_ovr, 1);

    // R9: interrupt gating
    irq_en = 3'b001; cyc(1);
    chk("R9", "irq per source", irq, 1);
    irq_en = 3'b100; cyc(1);
    chk("R9", "irq timeout source masked", irq, 0);
    irq_en = 3'b010; cyc(1);
    chk("R9", "irq ovr source", irq, 1);

    // R8: only the per_vld strobe, then all
    flag_clr = 5'b00001; cyc(1); flag_clr = '0; cyc(1);
    chk("R8", "per_vld cleared", per_vld, 0);
    chk("R8", "wid_vld kept", wid_vld, 1);
    clear_all();
    chk("R8", "wid_ovr cleared", wid_ovr, 0);
    chk("R8", "capture kept after clear", period, 10);
    chk("R9", "irq after clear", irq, 0);
    irq_en = 3'b000;

    // R10: change prescaler while running
    pulses(1'b0, 1'b0, 3, 3, 3);
    chk("R10", "flag set before change", per_vld, 1);
    cfg_psc = 16'd5;
    cyc(1);
    chk("R10", "cap1 zero after change", cap1, 0);
    chk("R10", "cap2 zero after change", cap2, 0);
    chk("R10", "per_vld zero after change", per_vld, 0);
    chk("R10", "wid_vld zero after change", wid_vld, 0);

    // R5: deselected pin ignored
    restart_cfg(1'b0, 1'b0, 16'd0);
    pulses(1'b1, 1'b0, 3, 4, 3);
    chk("R5", "pin_b ignored per_vld", per_vld, 0);
    chk("R5", "pin_b ignored cap2", cap2, 0);

    // R11: disabled block ignores the pin
    pulses(1'b0, 1'b0, 3, 4, 2);
    clear_all();
    cfg_en = 1'b0;
    cyc(2);
    pulses(1'b0, 1'b0, 3, 4, 3);
    chk("R11", "disabled per_vld", per_vld, 0);
    chk("R11", "disabled wid_vld", wid_vld, 0);
    chk("R11", "disabled period held", period, 7);

    // R2: counter wrap without an active edge
    restart_cfg(1'b0, 1'b0, 16'd0);
    irq_en = 3'b100;
    cyc(65530);
    chk("R2", "no timeout before wrap", timeout, 0);
    cyc(10);
    chk("R2", "timeout after wrap", timeout, 1);
    chk("R9", "irq on timeout", irq, 1);
    irq_en = 3'b000; cyc(1);
    chk("R9", "irq masked", irq, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule